// File: doc/BRIEF.md
# Interleaved Bank Group Scheduler

This block selects bank groups in the shared feature-data buffer of a streaming accelerator. The accelerator has two convolution stages and one fully connected stage, and they work on different frames at the same time. Unit `u` owns a window of four consecutive groups that starts at `GRP_STEP*u`. Adjacent windows overlap by two groups, and the overlapping groups carry data from one stage to the next. The frame parity of a unit picks the even or the odd pair inside its window. The layer index then picks which group of that pair the unit reads and which one it writes. The roles swap after every layer.

Each unit drives a one-cycle frame-start pulse, a one-cycle layer-done pulse and the number of layers in its current frame. The layer count is captured at frame start. For each unit the scheduler returns an active flag, a read group and a write group. All of them come from registered state, so they change on the clock edge that takes the pulse. A combinational flag reports when two active units select the same write group.

Top module: `bank_group_sched`

## Requirements
- R1: After reset every unit is inactive and `wr_conflict` is 0.
- R2: A frame-start pulse makes the unit active with layer index 0. While the unit is active, with parity p and layer index k, it reads group `GRP_STEP*u + p + 2*(k mod 2)` and writes group `GRP_STEP*u + p + 2*(1 - k mod 2)`.
- R3: A layer-done pulse that does not end the frame swaps the unit's read and write groups for the next layer.
- R4: Each unit keeps its own frame parity. The first frame after reset uses p = 0 (even groups), and each later frame-start of that unit toggles p.
- R5: The layer-done pulse for the last layer clears the unit's active flag. A captured layer count of 0 is treated as 1.
- R6: A layer-done pulse to an inactive unit has no effect. A frame that starts afterwards still begins at layer 0.
- R7: When a unit runs an odd number of layers, its write group in the last layer equals the first read group of the next unit for a frame of the same parity.
- R8: `wr_conflict` is 1 exactly when two active units select the same write group.
- R9: When the units are staggered by one frame each (unit u processes frame n-u), `wr_conflict` stays 0 in every cycle.
- R10: A frame-start to a unit that is already active restarts it at layer 0 with the toggled parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | NUM_UNITS | One-cycle frame-start pulse per unit |
| layer_done | input | NUM_UNITS | One-cycle layer-finished pulse per unit |
| layer_cnt | input | NUM_UNITS*CNT_W | Layer count per unit (unit u at bits u*CNT_W), captured at frame start |
| unit_act | output | NUM_UNITS | Unit has a frame in progress |
| rd_grp | output | NUM_UNITS*GW | Read group index per unit (GW = clog2(GRP_STEP*(NUM_UNITS-1)+4)) |
| wr_grp | output | NUM_UNITS*GW | Write group index per unit |
| wr_conflict | output | 1 | Two active units select the same write group |

## Verification
The bench uses the default build: three units, a group step of 2 and 6-bit layer counts, which gives group indices 0 to 7. With these values the overlap between neighbouring windows is real. A unit that runs one layer too many writes into the group its neighbour is writing, so the conflict flag can be forced as well as shown to stay low. Layer counts of 0, 1, 3 and 5 cover the last-layer rule, the count-zero rule and the handoff between units. A four-frame staggered run makes both parities meet on every shared group.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

    // group index inside a unit window: base, then parity, then pair half
    function automatic int grp_idx(input int base, input logic par, input logic hi);
        return base + int'(par) + (hi ? 2 : 0);
    endfunction

endpackage

// File: rtl/bgs_unit.sv
module bgs_unit #(
    parameter int BASE  = 0,
    parameter int GW    = 3,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             done_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             act_o,
    output logic [GW-1:0]    rd_o,
    output logic [GW-1:0]    wr_o
);
    import bgs_pkg::*;

    typedef struct packed {
        logic             act;
        logic             par;
        logic             nxt;
        logic [CNT_W-1:0] lyr;
        logic [CNT_W-1:0] tot;
    } ust_t;

    ust_t q, d;
    logic [CNT_W:0] lyr_inc;
    logic           last;

    always_comb begin
        d       = q;
        lyr_inc = {1'b0, q.lyr} + (CNT_W+1)'(1);
        last    = lyr_inc >= {1'b0, q.tot};
        if (start_i) begin
            d.act = 1'b1;
            d.par = q.nxt;
            d.nxt = ~q.nxt;
            d.lyr = '0;
            d.tot = cnt_i;
        end else if (q.act && done_i) begin
            if (last) begin
                d.act = 1'b0;
                d.lyr = '0;
            end else begin
                d.lyr = lyr_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act_o = q.act;
    assign rd_o  = GW'(grp_idx(BASE, q.par, q.lyr[0]));
    assign wr_o  = GW'(grp_idx(BASE, q.par, ~q.lyr[0]));

    // R2
    rd_wr_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |-> (rd_o != wr_o));

    // R2
    in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_o |-> (int'(wr_o) >= BASE && int'(wr_o) <= BASE + 3
                && int'(rd_o) >= BASE && int'(rd_o) <= BASE + 3));

    // R3
    role_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o && done_i && !start_i) |=> (!act_o || rd_o == $past(wr_o)));

    // R10
    start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (act_o && int'(rd_o) == BASE + int'(wr_o[0])));

    // R6
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_o && !start_i) |=> !act_o);
endmodule

// File: rtl/bgs_conflict.sv
module bgs_conflict #(
    parameter int NUM_UNITS = 3,
    parameter int GW        = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_UNITS-1:0]    act_i,
    input  logic [NUM_UNITS*GW-1:0] wr_i,
    output logic                    hit_o
);
    always_comb begin
        hit_o = 1'b0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            for (int j = i + 1; j < NUM_UNITS; j++) begin
                if (act_i[i] && act_i[j] && wr_i[i*GW +: GW] == wr_i[j*GW +: GW])
                    hit_o = 1'b1;
            end
        end
    end

    // R8
    hit_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ($countones(act_i) >= 2));
endmodule

// File: rtl/bank_group_sched.sv
module bank_group_sched #(
    parameter int NUM_UNITS = 3,
    parameter int GRP_STEP  = 2,
    parameter int CNT_W     = 6,
    localparam int GW       = $clog2(GRP_STEP*(NUM_UNITS-1) + 4)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_UNITS-1:0]       frame_start,
    input  logic [NUM_UNITS-1:0]       layer_done,
    input  logic [NUM_UNITS*CNT_W-1:0] layer_cnt,
    output logic [NUM_UNITS-1:0]       unit_act,
    output logic [NUM_UNITS*GW-1:0]    rd_grp,
    output logic [NUM_UNITS*GW-1:0]    wr_grp,
    output logic                       wr_conflict
);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        bgs_unit #(
            .BASE (GRP_STEP*u),
            .GW   (GW),
            .CNT_W(CNT_W)
        ) u_unit (
            .clk    (clk),
            .rst_n  (rst_n),
            .start_i(frame_start[u]),
            .done_i (layer_done[u]),
            .cnt_i  (layer_cnt[u*CNT_W +: CNT_W]),
            .act_o  (unit_act[u]),
            .rd_o   (rd_grp[u*GW +: GW]),
            .wr_o   (wr_grp[u*GW +: GW])
        );
    end

    bgs_conflict #(
        .NUM_UNITS(NUM_UNITS),
        .GW       (GW)
    ) u_conf (
        .clk  (clk),
        .rst_n(rst_n),
        .act_i(unit_act),
        .wr_i (wr_grp),
        .hit_o(wr_conflict)
    );
endmodule

// File: tb/sim_bank_group_sched.sv
module sim_bank_group_sched;
    localparam int NU = 3;
    localparam int CW = 6;
    localparam int GW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NU-1:0]    fs = '0;
    logic [NU-1:0]    ld = '0;
    logic [NU*CW-1:0] cnt = '0;
    logic [NU-1:0]    act;
    logic [NU*GW-1:0] rd, wr;
    logic             conf;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bank_group_sched #(.NUM_UNITS(NU), .GRP_STEP(2), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(fs), .layer_done(ld),
        .layer_cnt(cnt), .unit_act(act), .rd_grp(rd), .wr_grp(wr),
        .wr_conflict(conf)
    );

    function automatic int rdg(int u); return int'(rd[u*GW +: GW]); endfunction
    function automatic int wrg(int u); return int'(wr[u*GW +: GW]); endfunction
    function automatic int exp_rd(int u, int p, int k); return 2*u + p + 2*(k % 2); endfunction
    function automatic int exp_wr(int u, int p, int k); return 2*u + p + 2*(1 - k % 2); endfunction

    task automatic chk(string req, int actual, int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic chk_unit(string req, int u, int p, int k);
        chk(req, int'(act[u]), 1);
        chk(req, rdg(u), exp_rd(u, p, k));
        chk(req, wrg(u), exp_wr(u, p, k));
    endtask

    // inputs change at negedge, hold one cycle, results read at the next negedge
    task automatic pulse(logic [NU-1:0] s, logic [NU-1:0] d);
        fs = s; ld = d;
        @(negedge clk);
        fs = '0; ld = '0;
    endtask

    task automatic set_cnt(int u, int n);
        cnt[u*CW +: CW] = CW'(n);
    endtask

    task automatic do_reset();
        fs = '0; ld = '0; cnt = '0;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", int'(act), 0);
        chk("R1", int'(conf), 0);
    endtask

    task automatic t_single_frame();
        do_reset();
        set_cnt(0, 3);
        pulse(3'b001, 3'b000);
        chk_unit("R2", 0, 0, 0);
        for (int k = 1; k < 3; k++) begin
            pulse(3'b000, 3'b001);
            chk_unit("R3", 0, 0, k);
        end
        pulse(3'b000, 3'b001);
        chk("R5", int'(act[0]), 0);
    endtask

    task automatic t_parity();
        do_reset();
        set_cnt(1, 1);
        for (int f = 0; f < 3; f++) begin
            pulse(3'b010, 3'b000);
            chk_unit("R4", 1, f % 2, 0);
            pulse(3'b000, 3'b010);
            chk("R5", int'(act[1]), 0);
        end
    endtask

    task automatic t_zero_count();
        do_reset();
        set_cnt(2, 0);
        pulse(3'b100, 3'b000);
        chk_unit("R2", 2, 0, 0);
        pulse(3'b000, 3'b100);
        chk("R5", int'(act[2]), 0);
    endtask

    task automatic t_idle_done();
        do_reset();
        pulse(3'b000, 3'b001);
        chk("R6", int'(act[0]), 0);
        set_cnt(0, 5);
        pulse(3'b001, 3'b000);
        chk_unit("R6", 0, 0, 0);
    endtask

    task automatic t_handoff();
        int last_wr;
        do_reset();
        set_cnt(0, 5);
        set_cnt(1, 3);
        pulse(3'b001, 3'b000);
        for (int k = 1; k < 5; k++) pulse(3'b000, 3'b001);
        last_wr = wrg(0);
        chk("R7", last_wr, 2);
        pulse(3'b010, 3'b001);
        chk("R7", rdg(1), last_wr);
        chk("R7", int'(act[0]), 0);
    endtask

    task automatic t_conflict();
        do_reset();
        set_cnt(0, 3);
        set_cnt(1, 3);
        pulse(3'b011, 3'b000);
        chk("R8", int'(conf), 0);
        pulse(3'b000, 3'b010);
        chk("R8", wrg(1), 2);
        chk("R8", int'(conf), 1);
        pulse(3'b000, 3'b001);
        chk("R8", int'(conf), 0);
    endtask

    task automatic t_restart();
        do_reset();
        set_cnt(0, 5);
        pulse(3'b001, 3'b000);
        pulse(3'b000, 3'b001);
        chk_unit("R10", 0, 0, 1);
        pulse(3'b001, 3'b000);
        chk_unit("R10", 0, 1, 0);
    endtask

    task automatic t_stagger();
        int hits;
        do_reset();
        for (int u = 0; u < NU; u++) set_cnt(u, 3);
        hits = 0;
        for (int s = 0; s < 4 + NU - 1; s++) begin
            logic [NU-1:0] st;
            st = '0;
            for (int u = 0; u < NU; u++)
                if (s - u >= 0 && s - u < 4) st[u] = 1'b1;
            pulse(st, '0);
            if (conf) hits++;
            for (int u = 0; u < NU; u++)
                if (st[u]) chk_unit("R9", u, (s - u) % 2, 0);
            for (int k = 1; k < 3; k++) begin
                pulse('0, st);
                if (conf) hits++;
                for (int u = 0; u < NU; u++)
                    if (st[u]) chk_unit("R9", u, (s - u) % 2, k);
            end
            pulse('0, st);
            if (conf) hits++;
        end
        chk("R9", hits, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_single_frame();
                t_parity();
                t_zero_count();
                t_idle_done();
                t_handoff();
                t_conflict();
                t_restart();
                t_stagger();
                done = 1'b1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    total++;
                    bad++;
                    $display("FAIL watchdog actual=timeout expected=finish");
                end
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule